// File: doc/BRIEF.md
# Cycle-Bit Completion Queue Writer

This block is the device-side producer of a circular completion ring in host memory. The ring has no head or tail registers. Each time a command finishes, the block takes the command's tag, its SCSI status byte and its returned byte count. It packs them into an 8-byte entry and writes that entry through a 64-bit memory write port to the next slot of the ring. The final byte of each entry holds a cycle value. A host consumer knows its next expected cycle value, and it recognises a new entry when the cycle byte of a slot changes to that value.

The block keeps the slot index and the cycle value internally. The cycle value begins at 1 on the first pass through a zero-filled ring. It steps by one each time the index wraps from the last slot back to slot 0. A one-cycle completion-posted pulse follows every entry write and can feed an interrupt status bit. A clear input sends the index and the cycle back to their starting values and leaves the ring memory as it is. The ring must hold at least as many slots as the largest number of commands that can be outstanding at once. The block does not check how far the host has consumed.

Top module: `cqw_writer`

## Requirements
- R1: After reset, `mem_we_o` and `posted_o` are low. The first accepted completion is written to slot 0 with cycle value 1.
- R2: The 64-bit write word puts byte k at bits 8k+7:8k. Bytes 0..3 hold the byte count in big-endian order, so byte 0 is count[31:24]. Bytes 4..5 hold the tag in big-endian order, so byte 4 is tag[15:8]. Byte 6 holds the status and byte 7 holds the cycle value.
- R3: The write address is `base_addr_i + 8*index`, using the base present when the completion is accepted. The index advances by one for each accepted completion.
- R4: After slot DEPTH-1 is written, the next entry goes to slot 0, and that entry and every later one carry the cycle value plus one.
- R5: The cycle value is 8 bits wide and wraps modulo 256. After 255 full passes following a clear, the entry in slot 0 carries cycle 0.
- R6: A completion is accepted on any clock edge where `done_valid_i` is high and `clear_i` is low. Its write appears with `mem_we_o` high for exactly the following cycle. Completions may arrive on back-to-back cycles.
- R7: `posted_o` is high for exactly the one cycle that follows each cycle in which `mem_we_o` is high.
- R8: `clear_i` sets the index to 0 and the cycle value to 1 and causes no memory write. The next completion goes to slot 0 with cycle 1.
- R9: A completion presented in the same cycle as `clear_i` is dropped, and no write results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Restart ring: index 0, cycle 1 |
| base_addr_i | input | ADDR_W | Byte address of slot 0 |
| done_valid_i | input | 1 | A command completion is presented |
| done_tag_i | input | 16 | Command tag |
| done_status_i | input | 8 | SCSI status byte |
| done_nbytes_i | input | 32 | Returned byte count |
| mem_we_o | output | 1 | Entry write strobe |
| mem_addr_o | output | ADDR_W | Entry byte address |
| mem_wdata_o | output | 64 | Entry word |
| posted_o | output | 1 | Completion-posted pulse |

## Verification
If the index is wrong, the address of the very next write shows it one cycle after acceptance. If the cycle register is wrong, byte 7 of that same write shows it. A host waiting for a cycle value would then either miss the entry or read a stale one. A fault in the wrap logic stays hidden until slot DEPTH-1 has been written, so the stimulus runs the ring through several wraps. It also runs a long burst of 255 passes so that a cycle counter that is too narrow or saturates shows up on the next slot-0 entry. Faults in clear handling show up as a stray write, or as a wrong slot or cycle on the first entry after the clear.

// File: rtl/cqw_pkg.sv
package cqw_pkg;
  localparam int ENTRY_BYTES = 8;
  localparam int CYC_W       = 8;

  typedef struct packed {
    logic [31:0] nbytes;
    logic [15:0] tag;
    logic [7:0]  status;
  } cqw_done_t;
endpackage

// File: rtl/cqw_slot_ctr.sv
module cqw_slot_ctr #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     valid_i,
  output logic                     accept_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [cqw_pkg::CYC_W-1:0] cyc_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0]          idx_q;
  logic [cqw_pkg::CYC_W-1:0] cyc_q;
  logic                      accept;

  assign accept = valid_i & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cyc_q <= cqw_pkg::CYC_W'(1);
    end else if (clear_i) begin
      idx_q <= '0;
      cyc_q <= cqw_pkg::CYC_W'(1);
    end else if (accept) begin
      if (idx_q == LAST) begin
        idx_q <= '0;
        cyc_q <= cyc_q + 1'b1; // modulo 2^CYC_W
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign accept_o = accept;
  assign idx_o    = idx_q;
  assign cyc_o    = cyc_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && idx_q != LAST) |=>
      (idx_q == $past(idx_q) + 1'b1) && (cyc_q == $past(cyc_q)));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && idx_q == LAST) |=>
      (idx_q == '0) && (cyc_q == $past(cyc_q) + 1'b1));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (idx_q == '0) && (cyc_q == cqw_pkg::CYC_W'(1)));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> $stable(idx_q) && $stable(cyc_q));
endmodule

// File: rtl/cqw_entry_fmt.sv
module cqw_entry_fmt (
  input  cqw_pkg::cqw_done_t         done_i,
  input  logic [cqw_pkg::CYC_W-1:0]  cyc_i,
  output logic [63:0]                word_o
);
  logic [7:0] b [cqw_pkg::ENTRY_BYTES];

  always_comb begin
    b[0] = done_i.nbytes[31:24];
    b[1] = done_i.nbytes[23:16];
    b[2] = done_i.nbytes[15:8];
    b[3] = done_i.nbytes[7:0];
    b[4] = done_i.tag[15:8];
    b[5] = done_i.tag[7:0];
    b[6] = done_i.status;
    b[7] = cyc_i;
  end

  for (genvar k = 0; k < cqw_pkg::ENTRY_BYTES; k++) begin : g_lane
    assign word_o[8*k +: 8] = b[k];
  end
endmodule

// File: rtl/cqw_wr_stage.sv
module cqw_wr_stage #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [63:0]       word_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [63:0]       wdata_o,
  output logic              posted_o
);
  localparam int SHIFT = $clog2(cqw_pkg::ENTRY_BYTES);

  logic [ADDR_W-1:0] slot_off;
  assign slot_off = ADDR_W'({idx_i, {SHIFT{1'b0}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o     <= 1'b0;
      posted_o <= 1'b0;
    end else begin
      we_o     <= accept_i;
      posted_o <= we_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= base_i + slot_off;
      wdata_o <= word_i;
    end
  end

  p_posted_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> posted_o);

  p_posted_only_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |=> !posted_o);

  p_one_write_per_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> !we_o);
endmodule

// File: rtl/cqw_writer.sv
module cqw_writer #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              done_valid_i,
  input  logic [15:0]       done_tag_i,
  input  logic [7:0]        done_status_i,
  input  logic [31:0]       done_nbytes_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  output logic              posted_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                      accept;
  logic [IDX_W-1:0]          idx;
  logic [cqw_pkg::CYC_W-1:0] cyc;
  logic [63:0]               word;
  cqw_pkg::cqw_done_t        done;

  assign done = '{nbytes: done_nbytes_i, tag: done_tag_i, status: done_status_i};

  cqw_slot_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (done_valid_i),
    .accept_o(accept),
    .idx_o   (idx),
    .cyc_o   (cyc)
  );

  cqw_entry_fmt u_fmt (
    .done_i(done),
    .cyc_i (cyc),
    .word_o(word)
  );

  cqw_wr_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .base_i  (base_addr_i),
    .idx_i   (idx),
    .word_i  (word),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o),
    .posted_o(posted_o)
  );

  p_drop_on_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !mem_we_o);

  p_write_follows_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !clear_i) |=> mem_we_o);
endmodule

// File: tb/cqw_writer_tb.sv
`timescale 1ns/1ps
module cqw_writer_tb;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 32;
  localparam logic [31:0] BASE = 32'h0001_0000;

  typedef struct packed {
    logic [15:0] tag;
    logic [7:0]  status;
    logic [31:0] nbytes;
    logic [7:0]  slot;
    logic [7:0]  cyc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 8'h00, 32'hA1B2C3D4, 8'd0, 8'd1},
    '{16'hBEEF, 8'h02, 32'h00000200, 8'd1, 8'd1},
    '{16'h0001, 8'h08, 32'hFFFFFFFF, 8'd2, 8'd1},
    '{16'hFFFF, 8'h18, 32'h00000000, 8'd3, 8'd1},
    '{16'h00A5, 8'h28, 32'h01020304, 8'd0, 8'd2},
    '{16'h5A00, 8'h00, 32'h80000001, 8'd1, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, valid = 1'b0;
  logic [ADDR_W-1:0] base = BASE;
  logic [15:0] tag = '0;
  logic [7:0]  status = '0;
  logic [31:0] nbytes = '0;
  logic we, posted;
  logic [ADDR_W-1:0] addr;
  logic [63:0] wdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cqw_writer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .base_addr_i(base),
    .done_valid_i(valid), .done_tag_i(tag), .done_status_i(status),
    .done_nbytes_i(nbytes), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .posted_o(posted)
  );

  function automatic logic [63:0] exp_word(logic [15:0] t, logic [7:0] s,
                                           logic [31:0] n, logic [7:0] c);
    logic [63:0] w;
    w[7:0]   = n[31:24];
    w[15:8]  = n[23:16];
    w[23:16] = n[15:8];
    w[31:24] = n[7:0];
    w[39:32] = t[15:8];
    w[47:40] = t[7:0];
    w[55:48] = s;
    w[63:56] = c;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, write visible at next negedge, posted one later
  task automatic send(input logic [15:0] t, input logic [7:0] s, input logic [31:0] n,
                      input logic [ADDR_W-1:0] ea, input logic [7:0] ec, input string req);
    tag = t; status = s; nbytes = n; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(we === 1'b1, req, 64'(we), 64'd1);
    chk(addr === ea, req, 64'(addr), 64'(ea));
    chk(wdata === exp_word(t, s, n, ec), req, wdata, exp_word(t, s, n, ec));
    @(negedge clk);
    chk(posted === 1'b1 && we === 1'b0, {req, " R7"}, {62'd0, posted, we}, 64'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(we === 1'b0 && posted === 1'b0, "R1 reset", {62'd0, we, posted}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(we === 1'b0 && posted === 1'b0, "R1 idle", {62'd0, we, posted}, 64'd0);

    // table walk: R1 first entry, R2 layout, R3 address, R4 wrap
    for (int i = 0; i < NV; i++)
      send(VECS[i].tag, VECS[i].status, VECS[i].nbytes,
           BASE + 32'(VECS[i].slot) * 8, VECS[i].cyc, "R1/R2/R3/R4 vec");

    // R6 back-to-back: slots 2,3 cycle 2
    tag = 16'h0102; status = 8'h11; nbytes = 32'h11; valid = 1'b1;
    @(negedge clk);
    chk(we === 1'b1 && addr === BASE + 16, "R6 b2b first", 64'(addr), 64'(BASE + 16));
    tag = 16'h0304; status = 8'h22; nbytes = 32'h22;
    @(negedge clk);
    valid = 1'b0;
    chk(we === 1'b1 && addr === BASE + 24 &&
        wdata === exp_word(16'h0304, 8'h22, 32'h22, 8'd2), "R6 b2b second",
        wdata, exp_word(16'h0304, 8'h22, 32'h22, 8'd2));
    chk(posted === 1'b1, "R7 b2b", 64'(posted), 64'd1);
    @(negedge clk);
    chk(we === 1'b0 && posted === 1'b1, "R6 b2b end", {62'd0, we, posted}, 64'd1);
    @(negedge clk);

    // R8 clear with index 0, cycle 3 pending state
    send(16'h0AAA, 8'h00, 32'h10, BASE, 8'd3, "R4 third pass");
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(we === 1'b0, "R8 clear no write", 64'(we), 64'd0);
    @(negedge clk);
    chk(we === 1'b0, "R8 clear no write later", 64'(we), 64'd0);
    send(16'h0BBB, 8'h02, 32'h20, BASE, 8'd1, "R8 after clear");

    // R9 clear and valid together
    tag = 16'hDEAD; status = 8'h02; nbytes = 32'h5; valid = 1'b1; clear = 1'b1;
    @(negedge clk);
    valid = 1'b0; clear = 1'b0;
    chk(we === 1'b0, "R9 dropped", 64'(we), 64'd0);
    @(negedge clk);
    chk(posted === 1'b0, "R9 no post", 64'(posted), 64'd0);
    send(16'h0CCC, 8'h00, 32'h30, BASE, 8'd1, "R9 next slot 0");

    // R3 base sampled at accept
    base = 32'h0020_0000;
    send(16'h0DDD, 8'h00, 32'h40, 32'h0020_0008, 8'd1, "R3 new base");
    base = BASE;

    // R5: 255 passes after clear -> cycle 0
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    tag = 16'h7777; status = 8'h00; nbytes = 32'h1; valid = 1'b1;
    repeat (DEPTH * 255) @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    send(16'h0EEE, 8'h00, 32'h50, BASE, 8'd0, "R5 cycle wrap");
    send(16'h0FFF, 8'h00, 32'h60, BASE + 8, 8'd0, "R5 slot 1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule